// File: doc/BRIEF.md
# Managed-Flash Host Identification Sequencer

This block is the host-side controller that walks an embedded managed-flash device from power-up to the data-transfer standby state. After a start pulse it can first send a reset that asks the device for boot mode. It then polls the device's operating conditions until the device stops reporting busy, asks for the device identity and hands the device a host-chosen relative address. Once the address is assigned, the sequencer sits in standby and reports completion together with the assigned address.

It does not frame bits on the wire. Each command goes to a separate serializer as a 6-bit index and a 32-bit argument under a valid/ready handshake. The serializer returns one result per command that has a response: a status word, a busy flag, a missing-response flag and a CRC-error flag. A failed response or too many busy polls stops the sequence in an error state, and the error code names the step that failed. The signalling mode output tells the pad logic to run open-drain during identification and push-pull once the device is in data-transfer mode. The host can later retire the device to the inactive state, after which the sequencer stays silent until reset.

Top module: `mflash_ident_seq`

## Requirements
- R1: After reset, no command is requested and `done`, `err` and `push_pull` are low. `rca_out` and `err_code` are zero.
- R2: When `start` is accepted with `boot_req` high, the first command is index 0 with argument 0xF0F0F0F0. No response is awaited for it, and index 1 follows. With `boot_req` low, the first command is index 1.
- R3: Index 1 carries argument `OCR_ARG`. It is re-issued after every good response whose busy flag is set. A good response with busy clear is followed by index 2 with argument 0.
- R4: If the response to the `RETRY_MAX`-th index-1 command still reports busy, the sequencer enters error with code 2. Exactly `RETRY_MAX` index-1 commands are issued, and nothing follows them.
- R5: After the identity response, index 3 is sent with argument {address, 16'h0000}. A good response to it raises `done`, and `rca_out` then equals the address latched at start. While `done` is low, `rca_out` is zero.
- R6: A response flagged missing or CRC-failed aborts the sequence with no further commands. The error code is 1 for index 1, 3 for index 2 and 4 for index 3.
- R7: A start with a zero address gives error code 5 and issues no command.
- R8: `push_pull` is low while identification commands are requested. It is high in standby and while the deactivation command is pending.
- R9: A requested command keeps `cmd_valid`, `cmd_index` and `cmd_arg` unchanged until `cmd_ready` is seen.
- R10: In standby, a stray response or a `start` pulse changes nothing and issues no command.
- R11: `go_inactive` in standby issues index 15 with argument {address, 16'h0000}. After that the sequencer is inactive: `done` and `push_pull` are low, and no command is issued, even on `start`, until reset.
- R12: A `start` in the error state clears the error code and runs the sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin identification (accepted in idle or error) |
| boot_req | input | 1 | Send the boot-probe reset before polling |
| rca_cfg | input | 16 | Host-chosen relative address, latched at start |
| go_inactive | input | 1 | Retire the device from standby |
| cmd_valid | output | 1 | Command request to the serializer |
| cmd_ready | input | 1 | Serializer takes the command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response result present for one cycle |
| rsp_status | input | 32 | Status word of the response |
| rsp_busy | input | 1 | Device reports busy |
| rsp_timeout | input | 1 | No response arrived |
| rsp_crc_err | input | 1 | Response failed its CRC |
| done | output | 1 | Device is in data-transfer standby |
| push_pull | output | 1 | 1 = push-pull signalling, 0 = open-drain |
| rca_out | output | 16 | Assigned address while done |
| err | output | 1 | Sequence aborted |
| err_code | output | 4 | Failing step: 1 poll response, 2 poll limit, 3 identity, 4 address, 5 zero address |

## Verification
The bench targets the poll limit at exactly `RETRY_MAX` attempts. An off-by-one counter would show as one index-1 command too many or too few before code 2. Separate runs fail the response at each of the three steps. A design that mislabels its steps reports the wrong code, and one that does not abort keeps sending commands. A stall on `cmd_ready` catches a request that drops or changes before acceptance. Stray responses and start pulses in standby, and start pulses after deactivation, catch a state machine that wakes up from the wrong state.

// File: rtl/mfid_pkg.sv
package mfid_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BOOT_PROBE,
    ST_OP_COND,
    ST_WAIT_READY,
    ST_GET_ID,
    ST_SET_ADDR,
    ST_STANDBY,
    ST_DEACT,
    ST_INACTIVE,
    ST_ERROR
  } seq_state_e;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'd0,
    ERR_OPC_RSP   = 4'd1,
    ERR_OPC_LIMIT = 4'd2,
    ERR_ID_RSP    = 4'd3,
    ERR_ADDR_RSP  = 4'd4,
    ERR_RCA_ZERO  = 4'd5
  } seq_err_e;

  localparam logic [5:0]  CMD_RESET   = 6'd0;
  localparam logic [5:0]  CMD_OPCOND  = 6'd1;
  localparam logic [5:0]  CMD_IDENT   = 6'd2;
  localparam logic [5:0]  CMD_ADDR    = 6'd3;
  localparam logic [5:0]  CMD_INACT   = 6'd15;
  localparam logic [31:0] BOOT_ARG    = 32'hF0F0_F0F0;

endpackage

// File: rtl/mfid_rst_sync.sv
module mfid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/mfid_retry_ctr.sv
module mfid_retry_ctr #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != LIM));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LIM);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LIM));

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !at_limit) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mfid_cmd_mux.sv
module mfid_cmd_mux
  import mfid_pkg::*;
#(
  parameter int          ARG_W   = 32,
  parameter logic [31:0] OCR_ARG = 32'h40FF_8080
) (
  input  seq_state_e             st,
  input  logic [ARG_W/2-1:0]     rca,
  output logic [5:0]             idx,
  output logic [ARG_W-1:0]       arg
);
  localparam int RCA_W = ARG_W / 2;

  always_comb begin
    idx = CMD_RESET;
    arg = '0;
    unique case (st)
      ST_BOOT_PROBE: begin idx = CMD_RESET;  arg = ARG_W'(BOOT_ARG); end
      ST_OP_COND:    begin idx = CMD_OPCOND; arg = ARG_W'(OCR_ARG);  end
      ST_GET_ID:     begin idx = CMD_IDENT;  arg = '0;               end
      ST_SET_ADDR:   begin idx = CMD_ADDR;   arg = {rca, {RCA_W{1'b0}}}; end
      ST_DEACT:      begin idx = CMD_INACT;  arg = {rca, {RCA_W{1'b0}}}; end
      default:       begin idx = CMD_RESET;  arg = '0;               end
    endcase
  end
endmodule

// File: rtl/mflash_ident_seq.sv
module mflash_ident_seq
  import mfid_pkg::*;
#(
  parameter int          RETRY_MAX = 1000,
  parameter int          ARG_W     = 32,
  parameter logic [31:0] OCR_ARG   = 32'h40FF_8080
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               boot_req,
  input  logic [15:0]        rca_cfg,
  input  logic               go_inactive,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [5:0]         cmd_index,
  output logic [31:0]        cmd_arg,
  input  logic               rsp_valid,
  input  logic [31:0]        rsp_status,
  input  logic               rsp_busy,
  input  logic               rsp_timeout,
  input  logic               rsp_crc_err,
  output logic               done,
  output logic               push_pull,
  output logic [15:0]        rca_out,
  output logic               err,
  output logic [3:0]         err_code
);
  localparam int RCA_W = ARG_W / 2;

  logic       rst_s_n;
  seq_state_e st_q, st_d;
  logic       issued_q, issued_d;
  logic [RCA_W-1:0] rca_q;
  logic       rca_en;
  seq_err_e   err_q, err_d;
  logic       err_en;
  logic       hs, waiting, rsp_take, rsp_bad, start_ok;
  logic       at_limit, cnt_clr, cnt_inc;
  logic       status_unused;

  assign status_unused = ^rsp_status;

  mfid_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  mfid_retry_ctr #(.LIMIT(RETRY_MAX)) u_retry (
    .clk(clk), .rst_n(rst_s_n), .clr(cnt_clr), .inc(cnt_inc), .at_limit(at_limit)
  );

  mfid_cmd_mux #(.ARG_W(ARG_W), .OCR_ARG(OCR_ARG)) u_mux (
    .st(st_q), .rca(rca_q), .idx(cmd_index), .arg(cmd_arg)
  );

  always_comb begin
    cmd_valid = (st_q == ST_BOOT_PROBE) || (st_q == ST_OP_COND) || (st_q == ST_DEACT) ||
                (((st_q == ST_GET_ID) || (st_q == ST_SET_ADDR)) && !issued_q);
    hs        = cmd_valid && cmd_ready;
    waiting   = (st_q == ST_WAIT_READY) ||
                (((st_q == ST_GET_ID) || (st_q == ST_SET_ADDR)) && issued_q);
    rsp_take  = rsp_valid && waiting;
    rsp_bad   = rsp_timeout || rsp_crc_err;
    start_ok  = start && ((st_q == ST_IDLE) || (st_q == ST_ERROR));
    cnt_clr   = start_ok;
    cnt_inc   = hs && (st_q == ST_OP_COND);
    rca_en    = start_ok;
  end

  // next-state process
  always_comb begin
    st_d   = st_q;
    err_d  = err_q;
    err_en = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_ERROR: if (start) begin
        err_en = 1'b1;
        if (rca_cfg == '0) begin
          st_d  = ST_ERROR;
          err_d = ERR_RCA_ZERO;
        end else begin
          st_d  = boot_req ? ST_BOOT_PROBE : ST_OP_COND;
          err_d = ERR_NONE;
        end
      end
      ST_BOOT_PROBE: if (hs) st_d = ST_OP_COND;
      ST_OP_COND:    if (hs) st_d = ST_WAIT_READY;
      ST_WAIT_READY: if (rsp_take) begin
        if (rsp_bad) begin
          st_d = ST_ERROR; err_d = ERR_OPC_RSP; err_en = 1'b1;
        end else if (rsp_busy) begin
          if (at_limit) begin
            st_d = ST_ERROR; err_d = ERR_OPC_LIMIT; err_en = 1'b1;
          end else begin
            st_d = ST_OP_COND;
          end
        end else begin
          st_d = ST_GET_ID;
        end
      end
      ST_GET_ID: if (rsp_take) begin
        if (rsp_bad) begin
          st_d = ST_ERROR; err_d = ERR_ID_RSP; err_en = 1'b1;
        end else begin
          st_d = ST_SET_ADDR;
        end
      end
      ST_SET_ADDR: if (rsp_take) begin
        if (rsp_bad) begin
          st_d = ST_ERROR; err_d = ERR_ADDR_RSP; err_en = 1'b1;
        end else begin
          st_d = ST_STANDBY;
        end
      end
      ST_STANDBY:  if (go_inactive) st_d = ST_DEACT;
      ST_DEACT:    if (hs) st_d = ST_INACTIVE;
      ST_INACTIVE: st_d = ST_INACTIVE;
      default:     st_d = ST_IDLE;
    endcase
    issued_d = (st_d == st_q) ? (issued_q | hs) : 1'b0;
  end

  // register process
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      rca_q    <= '0;
      err_q    <= ERR_NONE;
    end else begin
      st_q     <= st_d;
      issued_q <= issued_d;
      if (rca_en) rca_q <= rca_cfg;
      if (err_en) err_q <= err_d;
    end
  end

  assign done      = (st_q == ST_STANDBY);
  assign err       = (st_q == ST_ERROR);
  assign push_pull = (st_q == ST_STANDBY) || (st_q == ST_DEACT);
  assign rca_out   = done ? rca_q : '0;
  assign err_code  = err_q;

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

  a_r5_rca_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> (rca_out != '0));

  a_r6_err_silent: assert property (@(posedge clk) disable iff (!rst_s_n)
    err |-> !cmd_valid);

  a_r8_open_drain_ident: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_valid && (cmd_index != CMD_INACT)) |-> !push_pull);

  a_r11_inactive_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_INACTIVE) |=> ((st_q == ST_INACTIVE) && !cmd_valid));

  a_r3_busy_repoll: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_WAIT_READY && rsp_valid && !rsp_bad && rsp_busy && !at_limit)
      |=> (cmd_valid && cmd_index == CMD_OPCOND));
endmodule

// File: tb/mflash_ident_seq_tb_top.sv
module mflash_ident_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          TB_RETRY   = 8;
  localparam logic [31:0] TB_OCR     = 32'h40FF_8080;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, boot_req, go_inactive, cmd_ready;
  logic [15:0] rca_cfg;
  logic        cmd_valid;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        rsp_valid, rsp_busy, rsp_timeout, rsp_crc_err;
  logic [31:0] rsp_status;
  logic        done, push_pull, err;
  logic [15:0] rca_out;
  logic [3:0]  err_code;

  int n_checks = 0;
  int n_fail   = 0;

  // serializer model state
  logic [5:0]  lg_idx [0:63];
  logic [31:0] lg_arg [0:63];
  logic        lg_pp  [0:63];
  int          lg_n;
  int          busy_left;
  int          fail_idx;
  int          fail_kind;
  int          pend_cnt;
  logic [5:0]  pend_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  mflash_ident_seq #(.RETRY_MAX(TB_RETRY), .ARG_W(32), .OCR_ARG(TB_OCR)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .boot_req(boot_req), .rca_cfg(rca_cfg),
    .go_inactive(go_inactive), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_busy(rsp_busy), .rsp_timeout(rsp_timeout),
    .rsp_crc_err(rsp_crc_err), .done(done), .push_pull(push_pull),
    .rca_out(rca_out), .err(err), .err_code(err_code)
  );

  // serializer/device model, acting at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_valid = 1'b0; rsp_busy = 1'b0; rsp_timeout = 1'b0; rsp_crc_err = 1'b0;
      rsp_status = '0; pend_cnt = 0; pend_idx = '0;
    end else begin
      rsp_valid = 1'b0; rsp_busy = 1'b0; rsp_timeout = 1'b0; rsp_crc_err = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt = pend_cnt - 1;
        if (pend_cnt == 0) begin
          rsp_valid  = 1'b1;
          rsp_status = 32'h0000_0900;
          if (pend_idx == 6'd1) begin
            rsp_busy   = (busy_left > 0);
            rsp_status = {!rsp_busy, 31'h00FF_8080};
            if (busy_left > 0) busy_left = busy_left - 1;
          end
          if (int'(pend_idx) == fail_idx) begin
            rsp_timeout = (fail_kind == 1);
            rsp_crc_err = (fail_kind == 2);
          end
        end
      end
      if (cmd_valid && cmd_ready) begin
        if (lg_n < 64) begin
          lg_idx[lg_n] = cmd_index;
          lg_arg[lg_n] = cmd_arg;
          lg_pp[lg_n]  = push_pull;
        end
        lg_n = lg_n + 1;
        if (cmd_index == 6'd1 || cmd_index == 6'd2 || cmd_index == 6'd3) begin
          pend_idx = cmd_index;
          pend_cnt = 2;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic setup(input int busy, input int fidx, input int fkind);
    @(negedge clk);
    lg_n = 0; busy_left = busy; fail_idx = fidx; fail_kind = fkind;
  endtask

  task automatic kick(input logic boot, input logic [15:0] rca);
    @(negedge clk);
    boot_req = boot; rca_cfg = rca; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  function automatic int count_idx(input logic [5:0] idx);
    int c = 0;
    for (int i = 0; i < lg_n && i < 64; i++) if (lg_idx[i] == idx) c++;
    return c;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; start = 0; boot_req = 0; go_inactive = 0; cmd_ready = 1; rca_cfg = '0;
    lg_n = 0; busy_left = 0; fail_idx = -1; fail_kind = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!cmd_valid, "R1", "cmd_valid after reset", 64'(cmd_valid), 0);
    check(!done && !err && !push_pull, "R1", "done/err/push_pull after reset",
          {61'd0, done, err, push_pull}, 0);
    check(rca_out == 0 && err_code == 0, "R1", "rca_out/err_code after reset",
          {44'd0, err_code, rca_out}, 0);
  endtask

  task automatic t_boot_full();
    setup(3, -1, 0);
    kick(1'b1, 16'h1234);
    wait_end();
    check(lg_n == 7, "R3", "command count with boot and 3 busy", 64'(lg_n), 7);
    check(lg_idx[0] == 0 && lg_arg[0] == 32'hF0F0F0F0, "R2", "boot probe command",
          {26'd0, lg_idx[0], lg_arg[0]}, {26'd0, 6'd0, 32'hF0F0F0F0});
    check(lg_idx[1] == 1 && lg_arg[1] == TB_OCR, "R2", "poll follows probe",
          {26'd0, lg_idx[1], lg_arg[1]}, {26'd0, 6'd1, TB_OCR});
    check(count_idx(6'd1) == 4, "R3", "poll count for 3 busy", 64'(count_idx(6'd1)), 4);
    check(lg_idx[5] == 2 && lg_arg[5] == 0, "R3", "identity after ready",
          {26'd0, lg_idx[5], lg_arg[5]}, {26'd0, 6'd2, 32'd0});
    check(lg_idx[6] == 3 && lg_arg[6] == 32'h1234_0000, "R5", "address command",
          {26'd0, lg_idx[6], lg_arg[6]}, {26'd0, 6'd3, 32'h1234_0000});
    check(done && !err && rca_out == 16'h1234, "R5", "done with address",
          {46'd0, done, err, rca_out}, {46'd0, 1'b1, 1'b0, 16'h1234});
    check(push_pull, "R8", "push-pull in standby", 64'(push_pull), 1);
    check(!lg_pp[1] && !lg_pp[5] && !lg_pp[6], "R8", "open-drain during identification",
          {61'd0, lg_pp[1], lg_pp[5], lg_pp[6]}, 0);
  endtask

  task automatic t_standby_ignore();
    int n0 = lg_n;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_crc_err = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(done && !err && lg_n == n0, "R10", "standby ignores stray response and start",
          {31'd0, done, err, 31'(lg_n)}, {31'd0, 1'b1, 1'b0, 31'(n0)});
  endtask

  task automatic t_deact();
    int n0 = lg_n;
    @(negedge clk);
    go_inactive = 1'b1;
    @(negedge clk);
    go_inactive = 1'b0;
    repeat (5) @(negedge clk);
    check(lg_n == n0 + 1 && lg_idx[n0] == 15 && lg_arg[n0] == 32'h1234_0000, "R11",
          "deactivation command", {26'd0, lg_idx[n0], lg_arg[n0]}, {26'd0, 6'd15, 32'h1234_0000});
    check(!done && !push_pull && rca_out == 0, "R11", "inactive outputs",
          {46'd0, done, push_pull, rca_out}, 0);
    kick(1'b0, 16'h0042);
    repeat (20) @(negedge clk);
    check(lg_n == n0 + 1 && !cmd_valid, "R11", "start ignored while inactive",
          64'(lg_n), 64'(n0 + 1));
  endtask

  task automatic t_noboot_stall();
    setup(0, -1, 0);
    cmd_ready = 1'b0;
    kick(1'b0, 16'h00A5);
    repeat (5) @(negedge clk);
    check(cmd_valid && cmd_index == 1 && cmd_arg == TB_OCR, "R9", "request held during stall",
          {25'd0, cmd_valid, cmd_index, cmd_arg}, {25'd0, 1'b1, 6'd1, TB_OCR});
    check(lg_n == 0 && !push_pull, "R8", "nothing taken, open-drain while stalled",
          {31'd0, push_pull, 32'(lg_n)}, 0);
    cmd_ready = 1'b1;
    wait_end();
    check(lg_n == 3 && lg_idx[0] == 1, "R2", "no probe when boot_req low",
          {26'd0, lg_idx[0], 32'(lg_n)}, {26'd0, 6'd1, 32'd3});
    check(done && rca_out == 16'h00A5, "R5", "done after stall", {47'd0, done, rca_out},
          {47'd0, 1'b1, 16'h00A5});
  endtask

  task automatic t_limit();
    setup(1000, -1, 0);
    kick(1'b0, 16'h0007);
    wait_end();
    check(err && err_code == 2, "R4", "poll limit error", {59'd0, err, err_code}, {59'd0, 1'b1, 4'd2});
    check(count_idx(6'd1) == TB_RETRY && lg_n == TB_RETRY, "R4", "poll attempts",
          64'(lg_n), 64'(TB_RETRY));
  endtask

  task automatic t_limit_edge();
    setup(TB_RETRY - 1, -1, 0);
    kick(1'b0, 16'h0007);
    wait_end();
    check(done && count_idx(6'd1) == TB_RETRY, "R4", "ready on last allowed poll",
          {31'd0, done, 32'(count_idx(6'd1))}, {31'd0, 1'b1, 32'(TB_RETRY)});
  endtask

  task automatic t_fail(input int idx, input int kind, input logic [3:0] exp_code);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    setup(1, idx, kind);
    kick(1'b1, 16'h0300);
    wait_end();
    check(err && err_code == exp_code, "R6", "error code of failing step",
          {59'd0, err, err_code}, {59'd0, 1'b1, exp_code});
    check(lg_n > 0 && int'(lg_idx[lg_n-1]) == idx, "R6", "no command after failure",
          64'(lg_idx[lg_n-1]), 64'(idx));
    check(!done && rca_out == 0, "R5", "no address when aborted", {47'd0, done, rca_out}, 0);
  endtask

  task automatic t_zero_rca();
    setup(0, -1, 0);
    kick(1'b1, 16'h0000);
    repeat (10) @(negedge clk);
    check(err && err_code == 5 && lg_n == 0, "R7", "zero address rejected",
          {27'd0, err, err_code, 32'(lg_n)}, {27'd0, 1'b1, 4'd5, 32'd0});
  endtask

  task automatic t_restart();
    setup(0, -1, 0);
    kick(1'b0, 16'h0BEE);
    @(negedge clk);
    check(err_code == 0, "R12", "error code cleared on restart", 64'(err_code), 0);
    wait_end();
    check(done && rca_out == 16'h0BEE, "R12", "sequence completes after error",
          {47'd0, done, rca_out}, {47'd0, 1'b1, 16'h0BEE});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary_and_end();
  end

  initial begin
    t_reset();
    t_boot_full();
    t_standby_ignore();
    t_deact();
    t_reset();
    t_noboot_stall();
    t_reset();
    t_limit();
    t_zero_rca();
    t_restart();
    t_reset();
    t_limit_edge();
    t_fail(1, 1, 4'd1);
    t_fail(2, 2, 4'd3);
    t_fail(3, 1, 4'd4);
    t_fail(3, 2, 4'd4);
    summary_and_end();
  end
endmodule